// File: doc/BRIEF.md
# Multi-Mode Output Compare Unit

This block drives three output pins from a free-running counter that lives elsewhere. Each channel holds a 32-bit compare value. When the counter equals that value on a count tick, the channel applies the pin action chosen in its mode field. The actions are toggle, drive low, drive high, or a low pulse that lasts one tick period. At the same time the channel sets its status flag.

Software reaches the block through a simple word-wide register port. The control word holds the three mode fields and three force strobes. A force strobe runs the channel's action at once, with no compare match needed. Flags are cleared by writing ones. Each flag has an enable bit, and the enabled flags are ORed into a single interrupt line.

Top module: `cmp_out_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, all pins, flags, the interrupt and the read data are 0.
- R2: A channel matches only when `cnt_tick` is 1 and `cnt_val` equals its compare value at a rising clock edge. The resulting pin action and flag update are visible right after that edge. With `cnt_tick` at 0 nothing happens.
- R3: In mode 1 a match inverts the channel's pin.
- R4: In mode 2 a match drives the pin to 0. In mode 3 a match drives the pin to 1.
- R5: In mode 4 a match drives the pin to 0. The pin returns to 1 after the next `cnt_tick` edge that does not itself start a new action.
- R6: Modes 0, 5, 6 and 7 leave the pin unchanged on a match.
- R7: Writing address 0 with bit 16+N set forces channel N's action on that edge. The action uses the mode held in the same written word. A force never sets a flag.
- R8: A match sets the channel's flag in any mode. Writing address 1 with bit N set clears flag N. A set in the same cycle wins over the clear.
- R9: `irq` is 1 one cycle after any flag whose enable bit is set. The enable bits are bits 2:0 of address 2.
- R10: Register map:
  - Address 0 holds channel N's mode at bits 3N+2:3N. Its force bits read back as 0.
  - Address 1 reads the flags.
  - Address 2 reads the enables.
  - Addresses 4, 5 and 6 hold the compare values of channels 0, 1 and 2.
  - `reg_rdata` loads on the edge where `reg_rd` is 1 and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 32 | Current value of the external counter |
| cnt_tick | input | 1 | Strobe marking a counter step |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pins | output | 3 | Compare output pins, bit N is channel N |
| flags | output | 3 | Compare status flags |
| irq | output | 1 | Interrupt request |

## Verification
Each stimulus is applied right after a falling edge. Pins, flags and read data are due after the next rising edge. The bench therefore compares them at the following falling edge against a model advanced by one step per cycle. The interrupt is one register further on, so the model derives it from its own previous flags and enables, which places it one cycle later. Directed checks cover:
- a pulse spanning a tick-free cycle
- a force combined with a mode change
- a flag clear arriving together with a match
- an unused mode code

// File: rtl/ocu_pkg.sv
`timescale 1ns/1ps
package ocu_pkg;
  typedef enum logic [2:0] {
    OM_OFF    = 3'd0,
    OM_TOGGLE = 3'd1,
    OM_LOW    = 3'd2,
    OM_HIGH   = 3'd3,
    OM_PULSE  = 3'd4
  } om_e;

  localparam int unsigned MODE_W  = 3;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_STAT  = 1;
  localparam int unsigned A_IEN   = 2;
  localparam int unsigned A_CMP0  = 4;
  localparam int unsigned FRC_LSB = 16;
endpackage

// File: rtl/ocu_regs.sv
`timescale 1ns/1ps
module ocu_regs #(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [AW-1:0]                 addr,
  input  logic [CW-1:0]                 wdata,
  input  logic [NCH-1:0]                flags,
  output logic [NCH*ocu_pkg::MODE_W-1:0] modes,
  output logic [NCH-1:0][CW-1:0]        cmps,
  output logic [NCH-1:0]                ien,
  output logic [NCH-1:0]                frc,
  output logic [NCH*ocu_pkg::MODE_W-1:0] frc_modes,
  output logic [NCH-1:0]                clr,
  output logic [CW-1:0]                 rdata
);
  import ocu_pkg::*;
  localparam int unsigned MBITS = NCH * MODE_W;
  localparam logic [AW-1:0] AD_CTRL = AW'(A_CTRL);
  localparam logic [AW-1:0] AD_STAT = AW'(A_STAT);
  localparam logic [AW-1:0] AD_IEN  = AW'(A_IEN);

  logic wr_ctrl, wr_stat, wr_ien;
  logic [CW-1:0] rd_nx;

  assign wr_ctrl   = wr && (addr == AD_CTRL);
  assign wr_stat   = wr && (addr == AD_STAT);
  assign wr_ien    = wr && (addr == AD_IEN);
  assign frc_modes = wdata[MBITS-1:0];
  assign clr       = wr_stat ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      modes <= '0;
      ien   <= '0;
    end else begin
      if (wr_ctrl) modes <= wdata[MBITS-1:0];
      if (wr_ien)  ien   <= wdata[NCH-1:0];
    end
  end

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      localparam logic [AW-1:0] AD_CMP = AW'(A_CMP0 + n);
      assign frc[n] = wr_ctrl && wdata[FRC_LSB + n];
      always_ff @(posedge clk) begin
        if (rst)                         cmps[n] <= '0;
        else if (wr && addr == AD_CMP)   cmps[n] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rd_nx = '0;
    if (addr == AD_CTRL)      rd_nx[MBITS-1:0] = modes;
    else if (addr == AD_STAT) rd_nx[NCH-1:0]   = flags;
    else if (addr == AD_IEN)  rd_nx[NCH-1:0]   = ien;
    for (int k = 0; k < NCH; k++)
      if (addr == AW'(A_CMP0 + k)) rd_nx = cmps[k];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_nx;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R10
  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> modes == $past(wdata[MBITS-1:0])); // R10
endmodule

// File: rtl/ocu_chan.sv
`timescale 1ns/1ps
module ocu_chan #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          tick,
  input  logic [CW-1:0] cmp,
  input  logic [2:0]    mode,
  input  logic          frc,
  input  logic [2:0]    frc_mode,
  input  logic          clr,
  output logic          pin,
  output logic          flag
);
  import ocu_pkg::*;

  logic       match, act, pact;
  logic [2:0] eff;

  assign match = tick && (cnt == cmp);
  assign eff   = frc ? frc_mode : mode;
  assign act   = (match || frc) && (eff >= 3'd1) && (eff <= 3'd4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin  <= 1'b0;
      pact <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (act) begin
        pact <= (eff == OM_PULSE);
        case (om_e'(eff))
          OM_TOGGLE: pin <= ~pin;
          OM_LOW:    pin <= 1'b0;
          OM_HIGH:   pin <= 1'b1;
          default:   pin <= 1'b0;
        endcase
      end else if (pact && tick) begin
        pin  <= 1'b1;
        pact <= 1'b0;
      end
      flag <= match | (flag & ~clr);
    end
  end

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
    match |=> flag); // R8
  AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (match && !frc && mode == 3'd1) |=> pin != $past(pin)); // R3
  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (rst)
    (match && !frc && mode == 3'd2) |=> !pin); // R4
  AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (match && !frc && mode == 3'd3) |=> pin); // R4
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (rst)
    (match && !frc && mode == 3'd4) |=> !pin); // R5
  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (rst)
    (!frc && !pact && (mode == 3'd0 || mode >= 3'd5)) |=> $stable(pin)); // R6
  AST_FORCE_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    (frc && !match && !flag) |=> !flag); // R7
endmodule

// File: rtl/cmp_out_unit.sv
`timescale 1ns/1ps
module cmp_out_unit #(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  cnt_val,
  input  logic           cnt_tick,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  output logic [NCH-1:0] pins,
  output logic [NCH-1:0] flags,
  output logic           irq
);
  import ocu_pkg::*;
  localparam int unsigned MBITS = NCH * MODE_W;

  logic [MBITS-1:0]        modes, frc_modes;
  logic [NCH-1:0][CW-1:0]  cmps;
  logic [NCH-1:0]          ien, frc, clr;

  ocu_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .flags(flags), .modes(modes), .cmps(cmps),
    .ien(ien), .frc(frc), .frc_modes(frc_modes), .clr(clr),
    .rdata(reg_rdata)
  );

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_chan
      ocu_chan #(.CW(CW)) u_chan (
        .clk(clk), .rst(rst), .cnt(cnt_val), .tick(cnt_tick),
        .cmp(cmps[n]),
        .mode(modes[n*MODE_W +: MODE_W]),
        .frc(frc[n]),
        .frc_mode(frc_modes[n*MODE_W +: MODE_W]),
        .clr(clr[n]),
        .pin(pins[n]), .flag(flags[n])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & ien);
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ien)) |=> irq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ien)) |=> !irq); // R9
endmodule

// File: tb/cmp_out_unit_test.sv
`timescale 1ns/1ps
module cmp_out_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cnt_val;
  logic        cnt_tick, reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [2:0]  pins, flags;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  logic [2:0]  m_mode [3];
  logic [31:0] m_cmp  [3];
  logic [2:0]  m_ien, m_flag, m_pin, m_pact;
  logic        m_irq;
  logic [31:0] m_rd;
  string       ptag   [3];

  cmp_out_unit uut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins(pins),
    .flags(flags), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v[8:0] = {m_mode[2], m_mode[1], m_mode[0]};
      3'd1: v[2:0] = m_flag;
      3'd2: v[2:0] = m_ien;
      3'd4: v = m_cmp[0];
      3'd5: v = m_cmp[1];
      3'd6: v = m_cmp[2];
      default: v = '0;
    endcase
    return v;
  endfunction

  // Advance the model by one clock edge with the given inputs.
  task automatic model_step(input logic t, input logic [31:0] c, input logic w,
                            input logic r, input logic [2:0] a, input logic [31:0] d);
    logic [2:0] nf, np, npa;
    nf = m_flag; np = m_pin; npa = m_pact;
    m_irq = |(m_flag & m_ien);
    if (r) m_rd = model_read(a);
    for (int ch = 0; ch < 3; ch++) begin
      logic mt, fr, cl;
      logic [2:0] md;
      mt = t && (c == m_cmp[ch]);
      fr = w && (a == 3'd0) && d[16+ch];
      cl = w && (a == 3'd1) && d[ch];
      md = fr ? d[3*ch +: 3] : m_mode[ch];
      if ((mt || fr) && md >= 3'd1 && md <= 3'd4) begin
        ptag[ch] = fr ? "R7" : (md == 3'd1 ? "R3" : (md == 3'd4 ? "R5" : "R4"));
        npa[ch] = (md == 3'd4);
        case (md)
          3'd1: np[ch] = ~m_pin[ch];
          3'd3: np[ch] = 1'b1;
          default: np[ch] = 1'b0;
        endcase
      end else if (m_pact[ch] && t) begin
        ptag[ch] = "R5";
        np[ch] = 1'b1; npa[ch] = 1'b0;
      end else begin
        ptag[ch] = "R6";
      end
      nf[ch] = mt | (m_flag[ch] & ~cl);
    end
    m_flag = nf; m_pin = np; m_pact = npa;
    if (w && a == 3'd0) for (int ch = 0; ch < 3; ch++) m_mode[ch] = d[3*ch +: 3];
    if (w && a == 3'd2) m_ien = d[2:0];
    if (w && a >= 3'd4 && a <= 3'd6) m_cmp[a-3'd4] = d;
  endtask

  task automatic step(input logic t, input logic [31:0] c, input logic w,
                      input logic r, input logic [2:0] a, input logic [31:0] d);
    cnt_tick = t; cnt_val = c; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    model_step(t, c, w, r, a, d);
    @(negedge clk);
    for (int ch = 0; ch < 3; ch++)
      chk(pins[ch] === m_pin[ch], ptag[ch], 32'(pins[ch]), 32'(m_pin[ch]));
    chk(flags === m_flag, "R8", 32'(flags), 32'(m_flag));
    chk(irq === m_irq, "R9", 32'(irq), 32'(m_irq));
    chk(reg_rdata === m_rd, "R10", reg_rdata, m_rd);
  endtask

  task automatic idle();
    step(1'b0, 32'd0, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cnt_val = '0; cnt_tick = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pins === 3'b000, "R1", 32'(pins), 0);
    chk(flags === 3'b000, "R1", 32'(flags), 0);
    chk(irq === 1'b0, "R1", 32'(irq), 0);
    chk(reg_rdata === 32'd0, "R1", reg_rdata, 0);
    for (int ch = 0; ch < 3; ch++) begin m_mode[ch] = '0; m_cmp[ch] = '0; ptag[ch] = "R1"; end
    m_ien = '0; m_flag = '0; m_pin = '0; m_pact = '0; m_irq = 0; m_rd = '0;
    rst = 1'b0;

    // Setup: ch0 high, ch1 pulse, ch2 toggle
    step(0, 0, 1, 0, 3'd4, 32'd5);
    step(0, 0, 1, 0, 3'd5, 32'd3);
    step(0, 0, 1, 0, 3'd6, 32'd7);
    step(0, 0, 1, 0, 3'd0, 32'(3 | (4 << 3) | (1 << 6)));
    // R2: equality without tick does nothing
    step(0, 5, 0, 0, 3'd0, 0);
    chk(pins[0] === 1'b0 && flags[0] === 1'b0, "R2", 32'({pins[0], flags[0]}), 0);
    step(1, 5, 0, 0, 3'd0, 0);
    chk(pins[0] === 1'b1 && flags[0] === 1'b1, "R2", 32'({pins[0], flags[0]}), 3);
    // R5 pulse spanning a tick-free cycle
    step(1, 3, 0, 0, 3'd0, 0);
    chk(pins[1] === 1'b0, "R5", 32'(pins[1]), 0);
    idle();
    chk(pins[1] === 1'b0, "R5", 32'(pins[1]), 0);
    step(1, 9, 0, 0, 3'd0, 0);
    chk(pins[1] === 1'b1, "R5", 32'(pins[1]), 1);
    // R3 toggle twice
    step(1, 7, 0, 0, 3'd0, 0);
    chk(pins[2] === 1'b1, "R3", 32'(pins[2]), 1);
    step(1, 7, 0, 0, 3'd0, 0);
    chk(pins[2] === 1'b0, "R3", 32'(pins[2]), 0);
    // R8 clear all flags
    step(0, 0, 1, 0, 3'd1, 32'd7);
    chk(flags === 3'b000, "R8", 32'(flags), 0);
    // R8 set wins over clear in the same cycle
    step(1, 5, 1, 0, 3'd1, 32'd1);
    chk(flags[0] === 1'b1, "R8", 32'(flags[0]), 1);
    step(0, 0, 1, 0, 3'd1, 32'd1);
    // R7 force ch0 with low mode from the same word, no flag
    step(0, 0, 1, 0, 3'd0, 32'(2 | (4 << 3) | (1 << 6) | (1 << 16)));
    chk(pins[0] === 1'b0 && flags[0] === 1'b0, "R7", 32'({pins[0], flags[0]}), 0);
    // R4 drive high via match after mode rewrite
    step(0, 0, 1, 0, 3'd0, 32'(3 | (4 << 3) | (1 << 6)));
    step(1, 5, 0, 0, 3'd0, 0);
    chk(pins[0] === 1'b1, "R4", 32'(pins[0]), 1);
    // R6 unused mode code leaves pin alone
    step(0, 0, 1, 0, 3'd0, 32'(6 | (4 << 3) | (1 << 6)));
    step(1, 5, 0, 0, 3'd0, 0);
    chk(pins[0] === 1'b1, "R6", 32'(pins[0]), 1);
    // R9 interrupt one cycle after enabled flag
    step(0, 0, 1, 0, 3'd2, 32'd1);
    idle();
    chk(irq === 1'b1, "R9", 32'(irq), 1);
    // R10 readback of compare value and control
    step(0, 0, 0, 1, 3'd5, 0);
    chk(reg_rdata === 32'd3, "R10", reg_rdata, 3);
    step(0, 0, 0, 1, 3'd0, 0);
    chk(reg_rdata === 32'(6 | (4 << 3) | (1 << 6)), "R10", reg_rdata, 32'(6 | (4 << 3) | (1 << 6)));

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic t, w, r;
      logic [2:0] a;
      logic [31:0] d, c;
      t = 1'($urandom % 2);
      c = $urandom % 8;
      w = ($urandom % 4) == 0;
      r = ($urandom % 3) == 0;
      a = 3'($urandom % 8);
      d = $urandom;
      if (a == 3'd0 && ($urandom % 4) != 0) d[18:16] = 3'b000;
      if (a >= 3'd4) d = $urandom % 8;
      step(t, c, w, r, a, d);
    end

    summary();
    $finish;
  end
endmodule